// File: doc/BRIEF.md
# SDRAM Burst Write Sequencer

This block performs one write burst into a 16-bit single-data-rate SDRAM whose row address, column address and data all share one pin group. A requester presents a row, a column and a word count on a request port. Once the request is taken, the block opens the row, waits a programmable number of idle command cycles, issues the write with the column on the shared pins, and then streams data words, each with its own pair of byte masks.

Data words arrive over a valid/ready stream. A word is placed on the pins in the cycle after its handshake. The burst is closed with a burst-terminate command when the requested count has been sent, or sooner if the stream has no word ready when one is expected. The clock enable stays high throughout. Between bursts the chip select is inactive and the shared pins are released, meaning their output enable is low and the pad ring tri-states them.

Top module: `sdram_wburst_seq`

## Requirements
- R1: Out of reset and whenever idle, `req_ready` is 1, `{sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n}` is 1111, `sd_ad_oe` is 0 and `sd_dqm` is 2'b11. `sd_cke` is 1 in every cycle.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. While a burst runs, `req_ready` is 0 and changes on the request inputs have no effect on the pins.
- R3: In the cycle after a request is taken, the command is Activate (`{cs_n,ras_n,cas_n,we_n}` = 0011) and `sd_ad` carries the row with `sd_ad_oe` = 1.
- R4: Exactly TRCD cycles (parameter, at least 1) of NOP (0111) with `sd_ad_oe` = 0 separate Activate from Write.
- R5: The Write command (0100) carries the column on `sd_ad` with `sd_ad_oe` = 1 and `sd_dqm` = 2'b11.
- R6: A word taken on an edge appears on `sd_ad` in the next cycle, with command NOP (0111), `sd_ad_oe` = 1, `sd_dqm[1]` (upper byte) equal to `wr_mask[1]` and `sd_dqm[0]` (lower byte) equal to `wr_mask[0]`. With `wr_valid` held high, the words follow one another in consecutive cycles.
- R7: `wr_ready` is 1 only in the Write cycle and in the data cycles, and only while fewer words than `req_len` have been taken. A burst never takes more than `req_len` words.
- R8: After the last of `req_len` words, the next cycle is Burst Terminate (0110) with `sd_ad_oe` = 0 and `sd_dqm` = 2'b11. The cycle after that is idle.
- R9: If `wr_valid` is 0 while `wr_ready` is 1, the next cycle is Burst Terminate, ending the burst early.
- R10: A `req_len` of 0 gives Write followed directly by Burst Terminate, and no word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Idle, request can be taken |
| req_row | input | AD_W | Row address |
| req_col | input | AD_W | Column address |
| req_len | input | LEN_W | Number of data words |
| wr_valid | input | 1 | Data word present |
| wr_ready | output | 1 | Data word can be taken |
| wr_data | input | AD_W | Data word |
| wr_mask | input | 2 | Byte masks, bit 1 upper, bit 0 lower, 1 = do not write |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 2 | Byte masks to the memory |
| sd_ad | output | AD_W | Shared address/data pins, output value |
| sd_ad_oe | output | 1 | Output enable for the shared pins |

## Verification
The assertions check the cycle-to-cycle rules on every cycle. These are: the idle pin state, Activate following an accepted request, a NOP gap before Write, a masked Write, every driven data cycle tracing back to a handshake, and starvation or the last word leading to Burst Terminate and then idle. Only the bench scenarios can show the values themselves: that the row, the column and each word land on the pins in order with their masks, that exactly TRCD gap cycles occur, and that the word count stops at `req_len`. To show this, the bench sweeps every length up to a small bound against every point at which the stream stops.

// File: rtl/sdram_wb_pkg.sv
package sdram_wb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_GAP,
    ST_WCMD,
    ST_DATA,
    ST_TERM
  } wb_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_BTERM = 4'b0110;
  localparam logic [3:0] CMD_DESEL = 4'b1111;
endpackage

// File: rtl/sdram_wb_ctrl.sv
module sdram_wb_ctrl
  import sdram_wb_pkg::*;
#(
  parameter int AD_W  = 16,
  parameter int LEN_W = 8,
  parameter int TRCD  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AD_W-1:0]  req_row,
  input  logic [AD_W-1:0]  req_col,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  input  logic             wr_valid,
  input  logic [AD_W-1:0]  wr_data,
  input  logic [1:0]       wr_mask,
  output logic             wr_ready,
  output wb_state_e        state_o,
  output logic [AD_W-1:0]  row_o,
  output logic [AD_W-1:0]  col_o,
  output logic [AD_W-1:0]  word_o,
  output logic [1:0]       mask_o
);
  localparam int GAP_W = (TRCD > 1) ? $clog2(TRCD) : 1;

  wb_state_e        state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [AD_W-1:0]  row_q, col_q, word_q;
  logic [1:0]       mask_q;
  logic             accept, take, rem_en, gap_done;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign wr_ready  = ((state_q == ST_WCMD) || (state_q == ST_DATA)) && (rem_q != '0);
  assign take      = wr_ready && wr_valid;

  // Gap counter: only built when more than one NOP is needed
  generate
    if (TRCD > 1) begin : g_gap_cnt
      logic [GAP_W-1:0] gap_q, gap_d;
      logic             gap_en;
      always_comb begin
        gap_en = 1'b0;
        gap_d  = gap_q;
        if (state_q == ST_ACT) begin
          gap_en = 1'b1;
          gap_d  = GAP_W'(TRCD - 1);
        end else if ((state_q == ST_GAP) && (gap_q != '0)) begin
          gap_en = 1'b1;
          gap_d  = gap_q - 1'b1;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      gap_q <= '0;
        else if (gap_en) gap_q <= gap_d;
      end
      assign gap_done = (gap_q == '0);
    end else begin : g_gap_one
      assign gap_done = 1'b1;
    end
  endgenerate

  // Next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ACT;
      ST_ACT:  state_d = ST_GAP;
      ST_GAP:  if (gap_done) state_d = ST_WCMD;
      ST_WCMD,
      ST_DATA: state_d = take ? ST_DATA : ST_TERM;
      ST_TERM: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rem_en = accept || take;
    rem_d  = accept ? req_len : (rem_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      row_q <= req_row;
      col_q <= req_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      mask_q <= 2'b11;
    end else if (take) begin
      word_q <= wr_data;
      mask_q <= wr_mask;
    end
  end

  assign state_o = state_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
  assign word_o  = word_q;
  assign mask_o  = mask_q;

  AST_NO_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wr_ready) else $error("take while idle"); // R7
  AST_TERM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TERM) |=> (state_q == ST_IDLE)) else $error("term not single"); // R8
endmodule

// File: rtl/sdram_wb_pins.sv
module sdram_wb_pins
  import sdram_wb_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  wb_state_e       state_i,
  input  logic [AD_W-1:0] row_i,
  input  logic [AD_W-1:0] col_i,
  input  logic [AD_W-1:0] word_i,
  input  logic [1:0]      mask_i,
  output logic            cke,
  output logic [3:0]      cmd,
  output logic [1:0]      dqm,
  output logic [AD_W-1:0] ad,
  output logic            ad_oe
);
  assign cke = 1'b1;

  always_comb begin
    cmd   = CMD_DESEL;
    dqm   = 2'b11;
    ad    = '0;
    ad_oe = 1'b0;
    unique case (state_i)
      ST_ACT: begin
        cmd   = CMD_ACT;
        ad    = row_i;
        ad_oe = 1'b1;
      end
      ST_GAP:  cmd = CMD_NOP;
      ST_WCMD: begin
        cmd   = CMD_WRITE;
        ad    = col_i;
        ad_oe = 1'b1;
      end
      ST_DATA: begin
        cmd   = CMD_NOP;
        ad    = word_i;
        dqm   = mask_i;
        ad_oe = 1'b1;
      end
      ST_TERM: cmd = CMD_BTERM;
      default: cmd = CMD_DESEL;
    endcase
  end
endmodule

// File: rtl/sdram_wburst_seq.sv
module sdram_wburst_seq
  import sdram_wb_pkg::*;
#(
  parameter int AD_W  = 16,
  parameter int LEN_W = 8,
  parameter int TRCD  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AD_W-1:0]  req_row,
  input  logic [AD_W-1:0]  req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AD_W-1:0]  wr_data,
  input  logic [1:0]       wr_mask,
  output logic             sd_cke,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [1:0]       sd_dqm,
  output logic [AD_W-1:0]  sd_ad,
  output logic             sd_ad_oe
);
  wb_state_e       state;
  logic [AD_W-1:0] row, col, word;
  logic [1:0]      mask;
  logic [3:0]      cmd;

  sdram_wb_ctrl #(.AD_W(AD_W), .LEN_W(LEN_W), .TRCD(TRCD)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_row(req_row), .req_col(req_col),
    .req_len(req_len), .req_ready(req_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_mask(wr_mask),
    .wr_ready(wr_ready),
    .state_o(state), .row_o(row), .col_o(col), .word_o(word), .mask_o(mask)
  );

  sdram_wb_pins #(.AD_W(AD_W)) pins_i (
    .state_i(state), .row_i(row), .col_i(col), .word_i(word), .mask_i(mask),
    .cke(sd_cke), .cmd(cmd), .dqm(sd_dqm), .ad(sd_ad), .ad_oe(sd_ad_oe)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  AST_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke) else $error("cke low"); // R1
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd == CMD_DESEL) && !sd_ad_oe && (sd_dqm == 2'b11)) else $error("idle pins"); // R1
  AST_ACCEPT_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == CMD_ACT) && sd_ad_oe) else $error("no activate"); // R3
  AST_ACT_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |=> (cmd == CMD_NOP) && !sd_ad_oe) else $error("no gap"); // R4
  AST_WRITE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE) |-> ($past(cmd) == CMD_NOP) && !$past(sd_ad_oe)) else $error("write w/o gap"); // R4
  AST_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE) |-> (sd_dqm == 2'b11) && sd_ad_oe) else $error("write cycle"); // R5
  AST_DATA_FROM_HS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_NOP) && sd_ad_oe) |-> $past(wr_valid && wr_ready)) else $error("data w/o hs"); // R6
  AST_STARVE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> (cmd == CMD_BTERM)) else $error("starve"); // R9
  AST_TERM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_BTERM) |-> !sd_ad_oe && (sd_dqm == 2'b11)) else $error("term drive"); // R8
  AST_TERM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_BTERM) |=> req_ready) else $error("term idle"); // R8
endmodule

// File: tb/sdram_wburst_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_wburst_seq_tb_top;
  localparam int AD_W  = 16;
  localparam int LEN_W = 4;
  localparam int TRCD  = 2;
  localparam logic [3:0] C_ACT = 4'b0011, C_NOP = 4'b0111, C_WR = 4'b0100,
                         C_BT = 4'b0110, C_DS = 4'b1111;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, req_valid, req_ready, wr_valid, wr_ready;
  logic [AD_W-1:0]  req_row, req_col, wr_data, sd_ad;
  logic [LEN_W-1:0] req_len;
  logic [1:0]       wr_mask, sd_dqm;
  logic             sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ad_oe;
  logic [3:0]       cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  int checks = 0;
  int errors = 0;

  sdram_wburst_seq #(.AD_W(AD_W), .LEN_W(LEN_W), .TRCD(TRCD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_mask(wr_mask),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_ad(sd_ad), .sd_ad_oe(sd_ad_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AD_W-1:0] word_of(input logic [AD_W-1:0] row, input int i);
    return (row ^ 16'hC35A) + AD_W'(i * 16'h0123);
  endfunction

  task automatic idle_chk(input string req);
    chk(req_ready == 1'b1, req, 32'(req_ready), 1);
    chk(cmd == C_DS, req, 32'(cmd), 32'(C_DS));
    chk(sd_ad_oe == 1'b0 && sd_dqm == 2'b11 && sd_cke == 1'b1, req,
        {29'd0, sd_cke, sd_ad_oe, sd_dqm[0]}, 32'h5);
  endtask

  task automatic run(input logic [AD_W-1:0] row, input logic [AD_W-1:0] col,
                     input int len, input int stop);
    int  sent;
    bit  done;
    bit  exp_rdy, give;
    int  exp_sent;
    sent = 0;
    done = 1'b0;
    @(negedge clk);
    idle_chk("R1 idle before burst");
    req_valid = 1'b1; req_row = row; req_col = col; req_len = LEN_W'(len);
    @(negedge clk);
    chk(cmd == C_ACT, "R3 activate cmd", 32'(cmd), 32'(C_ACT));
    chk(sd_ad_oe && sd_ad == row, "R3 row on pins", 32'(sd_ad), 32'(row));
    chk(!req_ready, "R2 busy", 32'(req_ready), 0);
    req_row = ~row; req_col = ~col; req_len = ~req_len;  // held valid: must be ignored (R2)
    for (int g = 0; g < TRCD; g++) begin
      @(negedge clk);
      chk(cmd == C_NOP && !sd_ad_oe, "R4 gap nop", {27'd0, sd_ad_oe, cmd}, 32'(C_NOP));
    end
    @(negedge clk);
    chk(cmd == C_WR, "R5 write cmd", 32'(cmd), 32'(C_WR));
    chk(sd_ad_oe && sd_ad == col && sd_dqm == 2'b11, "R5 column",
        {14'd0, sd_dqm, sd_ad}, {14'd0, 2'b11, col});
    for (int k = 0; k < 40 && !done; k++) begin
      exp_rdy = (sent < len);
      give    = (sent < stop);
      chk(wr_ready == exp_rdy, "R7 wr_ready", 32'(wr_ready), 32'(exp_rdy));
      wr_valid = give;
      wr_data  = word_of(row, sent);
      wr_mask  = 2'(sent);
      @(negedge clk);
      if (exp_rdy && give) begin
        chk(cmd == C_NOP && sd_ad_oe, "R6 data cycle cmd", {27'd0, sd_ad_oe, cmd}, {27'd1, C_NOP});
        chk(sd_ad == word_of(row, sent), "R6 data word", 32'(sd_ad), 32'(word_of(row, sent)));
        chk(sd_dqm == 2'(sent), "R6 byte masks", 32'(sd_dqm), 32'(2'(sent)));
        sent++;
      end else begin
        chk(cmd == C_BT, (len == 0) ? "R10 zero-length term" : (sent < len) ? "R9 early term" : "R8 final term",
            32'(cmd), 32'(C_BT));
        chk(!sd_ad_oe && sd_dqm == 2'b11, "R8 term releases pins", {29'd0, sd_ad_oe, sd_dqm}, 32'h3);
        done = 1'b1;
      end
    end
    wr_valid = 1'b0;
    req_valid = 1'b0;
    exp_sent = (stop < len) ? stop : len;
    chk(sent == exp_sent, "R7 word count", 32'(sent), 32'(exp_sent));
    @(negedge clk);
    idle_chk("R8 idle after term");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_row = '0; req_col = '0; req_len = '0;
    wr_valid = 1'b0; wr_data = '0; wr_mask = '0;
    repeat (3) @(negedge clk);
    idle_chk("R1 reset state");
    rst_n = 1'b1;
    for (int len = 0; len <= 7; len++) begin
      for (int stop = 0; stop <= len + 1; stop++) begin
        run(AD_W'(16'h1000 + len * 16 + stop), AD_W'(16'h0200 + len), len, stop);
      end
    end
    run(16'hFFFF, 16'h0000, 15, 15);   // maximum count, R6/R8
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule